// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block monitors two groups of general-purpose input pins, a 31-pin group called port 0 and a 14-pin group called port 2. It turns transitions on those pins into sticky pending flags. The pins are asynchronous to the block clock, so each one first passes through a two-flop synchroniser. A transition is then found by comparing the synchronised level with its value one clock earlier. Every pin has two enables, one for the low-to-high direction and one for the high-to-low direction. The two directions are latched into separate status words, so a pin with both enables set records each direction on its own.

Software reaches the block through a simple 32-bit register port: byte address, write strobe, write data, and read data that follows the address combinationally. Each port has:

- two read/write enable words;
- two read-only status words;
- one write-only clear word, in which a one clears both direction flags of that pin.

A summary word at offset zero shows which port has anything pending. A single registered interrupt request is raised while any flag in either port is set.

Top module: `gpio_edge_irq`

## Requirements
- R1: A pin transition is synchronised and compared against its previous synchronised level. When the pin changes just before clock edge k, the matching status bit is still clear after edge k+1 and is set after edge k+2.
- R2: A low-to-high transition sets only the rising status bit of that pin, and a high-to-low transition sets only the falling status bit. When both enables of a pin are set, both directions are latched independently.
- R3: A transition is latched only if its direction enable for that pin is set. Clearing an enable does not erase a status bit that is already set.
- R4: A status bit stays set until a clear write for its pin, whatever the pin does afterwards.
- R5: Writing a one to a bit of a port's clear word clears both the rising and the falling status bits of that pin. Zero bits have no effect, and reading a clear word returns zero.
- R6: If a clear write and a new enabled transition hit the same pin on the same clock edge, the new event wins and that status bit stays set.
- R7: The summary word (offset 0x00) has bit 0 set while any port 0 status bit is set and bit 2 set while any port 2 status bit is set. All of its other bits read zero.
- R8: `irq` is a register holding the OR of all status bits of both ports. It rises one clock after the first bit sets, and falls one clock after the last bit is cleared.
- R9: The byte offsets are as follows. Port 0 uses 0x04 rising status, 0x08 falling status, 0x0C clear, 0x10 rising enable and 0x14 falling enable. Port 2 uses 0x24, 0x28, 0x2C, 0x30 and 0x34 in the same roles. Enable words read back what was written.
- R10: Bits above a port's pin count read zero and ignore writes. Every other offset, including 0x18 to 0x20, 0x38, 0x3C and misaligned addresses, reads zero and ignores writes.
- R11: Synchronous active-low reset clears every enable, every status bit and `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| port0_pins | input | 31 | Asynchronous port 0 pin levels |
| port2_pins | input | 14 | Asynchronous port 2 pin levels |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The assertions check properties that must hold on every cycle:

- a newly set status bit always had its direction enable set one cycle earlier;
- a status bit only ever falls right after a clear write to its own port;
- `irq` tracks the OR of all pending flags with exactly one cycle of lag;
- the summary word, the clear words and the unimplemented upper bits always read as specified.

The synchroniser latency, the read-back of each register offset, and the choice between rising and falling direction under particular pin patterns can only be shown by the bench's scenarios. The same holds for the clear-versus-event collision on a single edge and the mid-run reset.

// File: rtl/gei_pkg.sv
// Package: shared register map constants and slot enumeration for the
// GPIO edge interrupt controller. Offsets are byte addresses, word aligned.
package gei_pkg;
    localparam int REG_W       = 32;
    localparam int ADDR_W      = 6;
    localparam int SUMMARY_OFS = 'h00;
    localparam int P0_GROUP    = 'h04;
    localparam int P2_GROUP    = 'h24;
    localparam int SLOT_STRIDE = 4;
    localparam int NUM_SLOTS   = 5;
    localparam int SUM_BIT_P0  = 0;
    localparam int SUM_BIT_P2  = 2;

    // Order of the registers inside one port group.
    typedef enum int unsigned {
        SLOT_RISE_ST = 0,
        SLOT_FALL_ST = 1,
        SLOT_CLEAR   = 2,
        SLOT_RISE_EN = 3,
        SLOT_FALL_EN = 4
    } slot_e;
endpackage

// File: rtl/gei_sync.sv
// Module: gei_sync
// Synchronises W asynchronous pin levels with two flops and flags the
// transitions by comparing with the value one clock earlier.
// Assumes: pins are level signals. Pulses shorter than a clock may be missed.
module gei_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Two-stage synchroniser followed by a history register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Transition flags, valid for one cycle each.
    assign rise_o = sync_q & ~prev_q;
    assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/gei_decode.sv
// Module: gei_decode
// Address match for one port group: one hit line per register slot.
// Assumes: full byte address compare, so misaligned addresses never hit.
module gei_decode
    import gei_pkg::*;
#(
    parameter int BASE = P0_GROUP
) (
    input  logic [ADDR_W-1:0]    addr_i,
    output logic [NUM_SLOTS-1:0] hit_o
);
    // One comparator per slot, each at its own offset from the group base.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int SLOT_ADDR = BASE + s * SLOT_STRIDE;
        assign hit_o[s] = (addr_i == ADDR_W'(SLOT_ADDR));
    end
endmodule

// File: rtl/gei_bank.sv
// Module: gei_bank
// Holds the enable and status state of one port of W pins. Status bits are
// sticky, cleared by a one in the clear word; a new event beats a clear.
// Assumes: the *_wr_i strobes are already qualified by the write strobe.
module gei_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic [W-1:0] fall_i,
    input  logic [W-1:0] wdata_i,
    input  logic         ren_wr_i,
    input  logic         fen_wr_i,
    input  logic         clr_wr_i,
    output logic [W-1:0] ren_o,
    output logic [W-1:0] fen_o,
    output logic [W-1:0] rst_o,
    output logic [W-1:0] fst_o,
    output logic         pend_o
);
    logic [W-1:0] ren_q;
    logic [W-1:0] fen_q;
    logic [W-1:0] clr_mask;

    // Enable registers, loaded from the write data on their strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ren_q <= '0;
            fen_q <= '0;
        end else begin
            if (ren_wr_i) ren_q <= wdata_i;
            if (fen_wr_i) fen_q <= wdata_i;
        end
    end

    // Clear mask: active only during a clear write.
    assign clr_mask = clr_wr_i ? wdata_i : '0;

    // One pair of sticky status flops per pin.
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic r_q;
        logic f_q;

        // Set on an enabled event, clear on a clear bit; the set dominates.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= 1'b0;
                f_q <= 1'b0;
            end else begin
                r_q <= (r_q & ~clr_mask[i]) | (rise_i[i] & ren_q[i]);
                f_q <= (f_q & ~clr_mask[i]) | (fall_i[i] & fen_q[i]);
            end
        end

        assign rst_o[i] = r_q;
        assign fst_o[i] = f_q;
    end

    assign ren_o  = ren_q;
    assign fen_o  = fen_q;
    assign pend_o = (|rst_o) | (|fst_o);
endmodule

// File: rtl/gpio_edge_irq.sv
// Module: gpio_edge_irq
// Two-port GPIO edge interrupt controller with a 32-bit register port.
// Port 0 has P0_PINS pins, port 2 has P2_PINS pins. Reads are combinational
// from bus_addr; writes take effect on the clock edge where bus_wr is high.
// Assumes: P0_PINS and P2_PINS are at most REG_W.
module gpio_edge_irq
    import gei_pkg::*;
#(
    parameter int P0_PINS = 31,
    parameter int P2_PINS = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [P0_PINS-1:0] port0_pins,
    input  logic [P2_PINS-1:0] port2_pins,
    output logic               irq
);
    logic [P0_PINS-1:0]   p0_rise_det, p0_fall_det;
    logic [P2_PINS-1:0]   p2_rise_det, p2_fall_det;
    logic [P0_PINS-1:0]   p0_rise_en, p0_fall_en, p0_rise_st, p0_fall_st;
    logic [P2_PINS-1:0]   p2_rise_en, p2_fall_en, p2_rise_st, p2_fall_st;
    logic [NUM_SLOTS-1:0] p0_hit, p2_hit;
    logic                 p0_pend, p2_pend;
    logic                 sum_hit;
    logic                 irq_q;
    logic                 wdata_unused;

    // Pin synchronisers and edge detectors, one per port.
    gei_sync #(.W(P0_PINS)) u_sync_p0 (
        .clk(clk), .rst_n(rst_n), .pin_i(port0_pins),
        .rise_o(p0_rise_det), .fall_o(p0_fall_det)
    );
    gei_sync #(.W(P2_PINS)) u_sync_p2 (
        .clk(clk), .rst_n(rst_n), .pin_i(port2_pins),
        .rise_o(p2_rise_det), .fall_o(p2_fall_det)
    );

    // Address decode for each port group and for the summary word.
    gei_decode #(.BASE(P0_GROUP)) u_dec_p0 (.addr_i(bus_addr), .hit_o(p0_hit));
    gei_decode #(.BASE(P2_GROUP)) u_dec_p2 (.addr_i(bus_addr), .hit_o(p2_hit));
    assign sum_hit = (bus_addr == ADDR_W'(SUMMARY_OFS));

    // Enable and status state, one bank per port.
    gei_bank #(.W(P0_PINS)) u_bank_p0 (
        .clk(clk), .rst_n(rst_n),
        .rise_i(p0_rise_det), .fall_i(p0_fall_det),
        .wdata_i(bus_wdata[P0_PINS-1:0]),
        .ren_wr_i(bus_wr & p0_hit[SLOT_RISE_EN]),
        .fen_wr_i(bus_wr & p0_hit[SLOT_FALL_EN]),
        .clr_wr_i(bus_wr & p0_hit[SLOT_CLEAR]),
        .ren_o(p0_rise_en), .fen_o(p0_fall_en),
        .rst_o(p0_rise_st), .fst_o(p0_fall_st),
        .pend_o(p0_pend)
    );
    gei_bank #(.W(P2_PINS)) u_bank_p2 (
        .clk(clk), .rst_n(rst_n),
        .rise_i(p2_rise_det), .fall_i(p2_fall_det),
        .wdata_i(bus_wdata[P2_PINS-1:0]),
        .ren_wr_i(bus_wr & p2_hit[SLOT_RISE_EN]),
        .fen_wr_i(bus_wr & p2_hit[SLOT_FALL_EN]),
        .clr_wr_i(bus_wr & p2_hit[SLOT_CLEAR]),
        .ren_o(p2_rise_en), .fen_o(p2_fall_en),
        .rst_o(p2_rise_st), .fst_o(p2_fall_st),
        .pend_o(p2_pend)
    );

    // Write data bits above the wider port are intentionally not stored.
    assign wdata_unused = ^bus_wdata;

    // Read multiplexer: zero for clear words, reserved and unmapped offsets.
    always_comb begin
        bus_rdata = '0;
        if (sum_hit) begin
            bus_rdata[SUM_BIT_P0] = p0_pend;
            bus_rdata[SUM_BIT_P2] = p2_pend;
        end
        if (p0_hit[SLOT_RISE_ST]) bus_rdata[P0_PINS-1:0] = p0_rise_st;
        if (p0_hit[SLOT_FALL_ST]) bus_rdata[P0_PINS-1:0] = p0_fall_st;
        if (p0_hit[SLOT_RISE_EN]) bus_rdata[P0_PINS-1:0] = p0_rise_en;
        if (p0_hit[SLOT_FALL_EN]) bus_rdata[P0_PINS-1:0] = p0_fall_en;
        if (p2_hit[SLOT_RISE_ST]) bus_rdata[P2_PINS-1:0] = p2_rise_st;
        if (p2_hit[SLOT_FALL_ST]) bus_rdata[P2_PINS-1:0] = p2_fall_st;
        if (p2_hit[SLOT_RISE_EN]) bus_rdata[P2_PINS-1:0] = p2_rise_en;
        if (p2_hit[SLOT_FALL_EN]) bus_rdata[P2_PINS-1:0] = p2_fall_en;
    end

    // Registered combined interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= p0_pend | p2_pend;
    end

    assign irq = irq_q;
endmodule

// File: rtl/gei_checker.sv
// Module: gei_checker
// Cycle-level properties of gpio_edge_irq, attached with bind below.
// Assumes: the bench holds reset for several cycles before release.
module gei_checker
    import gei_pkg::*;
#(
    parameter int P0_W = 31,
    parameter int P2_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              irq,
    input logic [P0_W-1:0]   p0_rise_st,
    input logic [P0_W-1:0]   p0_fall_st,
    input logic [P0_W-1:0]   p0_rise_en,
    input logic [P0_W-1:0]   p0_fall_en,
    input logic [P2_W-1:0]   p2_rise_st,
    input logic [P2_W-1:0]   p2_fall_st,
    input logic [P2_W-1:0]   p2_rise_en,
    input logic [P2_W-1:0]   p2_fall_en
);
    localparam logic [ADDR_W-1:0] P0_CLR = ADDR_W'(P0_GROUP + 2 * SLOT_STRIDE);
    localparam logic [ADDR_W-1:0] P2_CLR = ADDR_W'(P2_GROUP + 2 * SLOT_STRIDE);
    localparam logic [ADDR_W-1:0] P0_LO  = ADDR_W'(P0_GROUP);
    localparam logic [ADDR_W-1:0] P0_HI  = ADDR_W'(P0_GROUP + 4 * SLOT_STRIDE);
    localparam logic [ADDR_W-1:0] P2_LO  = ADDR_W'(P2_GROUP);
    localparam logic [ADDR_W-1:0] P2_HI  = ADDR_W'(P2_GROUP + 4 * SLOT_STRIDE);

    logic any_pend;
    logic clr0_wr, clr2_wr;
    assign any_pend = (|p0_rise_st) | (|p0_fall_st) | (|p2_rise_st) | (|p2_fall_st);
    assign clr0_wr  = bus_wr && (bus_addr == P0_CLR);
    assign clr2_wr  = bus_wr && (bus_addr == P2_CLR);

    assert_rise_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((p0_rise_st & ~$past(p0_rise_st) & ~$past(p0_rise_en)) == '0) &&
        ((p2_rise_st & ~$past(p2_rise_st) & ~$past(p2_rise_en)) == '0));

    assert_fall_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((p0_fall_st & ~$past(p0_fall_st) & ~$past(p0_fall_en)) == '0) &&
        ((p2_fall_st & ~$past(p2_fall_st) & ~$past(p2_fall_en)) == '0));

    assert_p0_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(p0_rise_st) & ~p0_rise_st) | ($past(p0_fall_st) & ~p0_fall_st)) != '0)
        |-> $past(clr0_wr));

    assert_p2_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(p2_rise_st) & ~p2_rise_st) | ($past(p2_fall_st) & ~p2_fall_st)) != '0)
        |-> $past(clr2_wr));

    assert_clear_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == P0_CLR || bus_addr == P2_CLR) |-> (bus_rdata == '0));

    assert_summary_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == '0) |-> (bus_rdata == ((REG_W'((|p0_rise_st) | (|p0_fall_st)) << SUM_BIT_P0) |
                                            (REG_W'((|p2_rise_st) | (|p2_fall_st)) << SUM_BIT_P2))));

    assert_irq_rises_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> irq);

    assert_irq_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |=> !irq);

    assert_p0_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= P0_LO && bus_addr <= P0_HI) |-> ((bus_rdata >> P0_W) == '0));

    assert_p2_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= P2_LO && bus_addr <= P2_HI) |-> ((bus_rdata >> P2_W) == '0));
endmodule

bind gpio_edge_irq gei_checker #(.P0_W(P0_PINS), .P2_W(P2_PINS)) u_gei_checker (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rdata(bus_rdata), .irq(irq),
    .p0_rise_st(p0_rise_st), .p0_fall_st(p0_fall_st),
    .p0_rise_en(p0_rise_en), .p0_fall_en(p0_fall_en),
    .p2_rise_st(p2_rise_st), .p2_fall_st(p2_fall_st),
    .p2_rise_en(p2_rise_en), .p2_fall_en(p2_fall_en)
);

// File: tb/gpio_edge_irq_test.sv
// Bench for gpio_edge_irq: a table of pin patterns walked by one loop,
// then directed tests for latency, enables, clears, collisions and reset.
module gpio_edge_irq_test;
    localparam logic [5:0] A_SUM    = 6'h00;
    localparam logic [5:0] A_P0_RST = 6'h04;
    localparam logic [5:0] A_P0_FST = 6'h08;
    localparam logic [5:0] A_P0_CLR = 6'h0C;
    localparam logic [5:0] A_P0_REN = 6'h10;
    localparam logic [5:0] A_P0_FEN = 6'h14;
    localparam logic [5:0] A_P2_RST = 6'h24;
    localparam logic [5:0] A_P2_FST = 6'h28;
    localparam logic [5:0] A_P2_CLR = 6'h2C;
    localparam logic [5:0] A_P2_REN = 6'h30;
    localparam logic [5:0] A_P2_FEN = 6'h34;

    localparam int NVEC = 6;
    // Each entry: {port 0 pins (31 bits), port 2 pins (14 bits)}.
    localparam logic [44:0] VEC [NVEC] = '{
        {31'h00000005, 14'h0003},
        {31'h7FFFFFFF, 14'h3FFF},
        {31'h00000000, 14'h0000},
        {31'h5555AAAA, 14'h2AAA},
        {31'h2AAA5555, 14'h1555},
        {31'h40010000, 14'h2001}
    };
    localparam logic [30:0] EN_R0 = 31'h7FFFFFFF;
    localparam logic [30:0] EN_F0 = 31'h0000FFFF;
    localparam logic [13:0] EN_R2 = 14'h3FFF;
    localparam logic [13:0] EN_F2 = 14'h00FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [30:0] p0_pins = '0;
    logic [13:0] p2_pins = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_edge_irq uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port0_pins(p0_pins), .port2_pins(p2_pins), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(A_P0_CLR, 32'hFFFFFFFF);
        wr(A_P2_CLR, 32'hFFFFFFFF);
        wait_cyc(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [30:0] old0, new0;
        logic [13:0] old2, new2;
        wait_cyc(5);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state of every mapped word and irq.
        rd_chk("R11 sum", A_SUM, 0);
        rd_chk("R11 p0 rst", A_P0_RST, 0);
        rd_chk("R11 p0 fst", A_P0_FST, 0);
        rd_chk("R11 p0 ren", A_P0_REN, 0);
        rd_chk("R11 p0 fen", A_P0_FEN, 0);
        rd_chk("R11 p2 rst", A_P2_RST, 0);
        rd_chk("R11 p2 fst", A_P2_FST, 0);
        rd_chk("R11 p2 ren", A_P2_REN, 0);
        rd_chk("R11 p2 fen", A_P2_FEN, 0);
        chk("R11 irq", 32'(irq), 0);

        // R9: distinct values in each enable word read back without aliasing.
        wr(A_P0_REN, 32'h12345678);
        wr(A_P0_FEN, 32'h0ABCDEF0);
        wr(A_P2_REN, 32'h00001234);
        wr(A_P2_FEN, 32'h00000567);
        rd_chk("R9 p0 ren", A_P0_REN, 32'h12345678);
        rd_chk("R9 p0 fen", A_P0_FEN, 32'h0ABCDEF0);
        rd_chk("R9 p2 ren", A_P2_REN, 32'h00001234);
        rd_chk("R9 p2 fen", A_P2_FEN, 32'h00000567);

        // R10: upper bits ignored on write; reserved offsets inert.
        wr(A_P0_REN, 32'hFFFFFFFF);
        wr(A_P2_REN, 32'hFFFFFFFF);
        rd_chk("R10 p0 ren mask", A_P0_REN, 32'h7FFFFFFF);
        rd_chk("R10 p2 ren mask", A_P2_REN, 32'h00003FFF);
        wr(6'h18, 32'hFFFFFFFF);
        wr(6'h20, 32'hFFFFFFFF);
        wr(6'h38, 32'hFFFFFFFF);
        wr(6'h11, 32'h00000000);
        rd_chk("R10 rsvd 18", 6'h18, 0);
        rd_chk("R10 rsvd 1C", 6'h1C, 0);
        rd_chk("R10 rsvd 38", 6'h38, 0);
        rd_chk("R10 misaligned", 6'h11, 0);
        rd_chk("R10 p0 ren kept", A_P0_REN, 32'h7FFFFFFF);
        rd_chk("R10 p0 fen kept", A_P0_FEN, 32'h0ABCDEF0);
        rd_chk("R5 p0 clr reads 0", A_P0_CLR, 0);
        rd_chk("R5 p2 clr reads 0", A_P2_CLR, 0);

        // Table loop: R1 R2 R7 R8 R9 under several pin patterns.
        wr(A_P0_REN, 32'(EN_R0));
        wr(A_P0_FEN, 32'(EN_F0));
        wr(A_P2_REN, 32'(EN_R2));
        wr(A_P2_FEN, 32'(EN_F2));
        old0 = '0; old2 = '0;
        for (int v = 0; v < NVEC; v++) begin
            logic [30:0] er0, ef0;
            logic [13:0] er2, ef2;
            logic [31:0] esum;
            new0 = VEC[v][44:14];
            new2 = VEC[v][13:0];
            @(negedge clk);
            p0_pins = new0; p2_pins = new2;
            wait_cyc(4);
            er0 = new0 & ~old0 & EN_R0;
            ef0 = ~new0 & old0 & EN_F0;
            er2 = new2 & ~old2 & EN_R2;
            ef2 = ~new2 & old2 & EN_F2;
            esum = {29'b0, |{er2, ef2}, 1'b0, |{er0, ef0}};
            rd_chk("R2 table p0 rise", A_P0_RST, 32'(er0));
            rd_chk("R2 table p0 fall", A_P0_FST, 32'(ef0));
            rd_chk("R2 table p2 rise", A_P2_RST, 32'(er2));
            rd_chk("R2 table p2 fall", A_P2_FST, 32'(ef2));
            rd_chk("R7 table summary", A_SUM, esum);
            chk("R8 table irq", 32'(irq), 32'(esum != 0));
            clear_all();
            rd_chk("R5 table cleared p0", A_P0_RST, 0);
            rd_chk("R5 table cleared p2", A_P2_FST, 0);
            old0 = new0; old2 = new2;
        end

        // R1 latency and R8 rise timing on port 0 pin 0.
        @(negedge clk);
        p0_pins[0] = 1'b1;
        wait_cyc(2);
        rd_chk("R1 not yet after k+1", A_P0_RST, 0);
        wait_cyc(1);
        rd_chk("R1 set after k+2", A_P0_RST, 32'h1);
        chk("R8 irq still low", 32'(irq), 0);
        wait_cyc(1);
        chk("R8 irq high", 32'(irq), 1);

        // R4: flag stays set while the pin keeps changing without a clear.
        p0_pins[0] = 1'b0;
        wait_cyc(20);
        rd_chk("R4 sticky", A_P0_RST, 32'h1);

        // R8: irq falls one clock after the clear.
        wr(A_P0_CLR, 32'h1);
        rd_chk("R5 pin0 cleared", A_P0_RST, 0);
        chk("R8 irq lags clear", 32'(irq), 1);
        wait_cyc(1);
        chk("R8 irq low", 32'(irq), 0);

        // R3: disabled direction not latched; disabling keeps a set bit.
        wr(A_P0_REN, 32'(EN_R0 & ~31'h00100000));
        @(negedge clk);
        p0_pins[20] = 1'b1;
        wait_cyc(4);
        rd_chk("R3 disabled rise", A_P0_RST, 0);
        @(negedge clk);
        p0_pins[5] = 1'b1;
        wait_cyc(4);
        wr(A_P0_REN, 0);
        wait_cyc(2);
        rd_chk("R3 kept after disable", A_P0_RST, 32'h20);
        clear_all();
        wr(A_P0_REN, 32'(EN_R0));

        // R2 and R5: both directions on port 2 pin 3; zero clear is inert.
        @(negedge clk);
        p2_pins[3] = 1'b1;
        wait_cyc(4);
        p2_pins[3] = 1'b0;
        wait_cyc(4);
        rd_chk("R2 both rise", A_P2_RST, 32'h8);
        rd_chk("R2 both fall", A_P2_FST, 32'h8);
        rd_chk("R7 port2 only", A_SUM, 32'h4);
        wr(A_P2_CLR, 32'h0);
        rd_chk("R5 zero clear rise", A_P2_RST, 32'h8);
        rd_chk("R5 zero clear fall", A_P2_FST, 32'h8);
        wr(A_P2_CLR, 32'h8);
        rd_chk("R5 clear both rise", A_P2_RST, 0);
        rd_chk("R5 clear both fall", A_P2_FST, 0);

        // R6: clear on the same edge as a new rising event on port 0 pin 6.
        @(negedge clk);
        p0_pins[6] = 1'b1;
        wait_cyc(4);
        p0_pins[6] = 1'b0;
        wait_cyc(4);
        p0_pins[6] = 1'b1;
        wait_cyc(2);
        bus_addr = A_P0_CLR; bus_wdata = 32'h40; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd_chk("R6 event wins", A_P0_RST, 32'h40);
        rd_chk("R6 fall still cleared", A_P0_FST, 0);
        wait_cyc(2);
        chk("R8 irq with pending", 32'(irq), 1);

        // R11: reset mid-run clears enables, status and irq.
        @(negedge clk);
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk("R11 mid p0 rst", A_P0_RST, 0);
        rd_chk("R11 mid p0 ren", A_P0_REN, 0);
        rd_chk("R11 mid p2 fen", A_P2_FEN, 0);
        rd_chk("R11 mid sum", A_SUM, 0);
        chk("R11 mid irq", 32'(irq), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule